// File: doc/BRIEF.md
# Sigma-Delta ADC Bring-Up and Calibration Sequencer

This block is a control state machine that takes a sigma-delta converter from power-on to a calibrated, idle state. It does not move serial bits itself. It issues one request at a time to a separate serial register engine and then reacts to that engine's responses and to the converter's ready indication.

After `start`, the sequence runs in this order:

1. Send a serial-interface reset of 32 ones.
2. Wait a programmable settle time.
3. Read the identity byte and check it.
4. Program the operating-mode word, the configuration word and the excitation-current register.
5. Run six internal calibrations: zero-scale then full-scale, on each of input channels 0, 1 and 2.

When the last calibration reports ready, `done` rises. While `done` is high, a gain update may be presented. If it changes the configuration word, the word is rewritten and all six calibrations run again. If it leaves the word as it is, nothing is sent. A gain update is taken only while `done` is high.

Requests leave on a valid/ready channel. Once `req_valid` is high, the request fields hold steady until the cycle in which `req_ready` is also high, and that cycle is the transfer. The engine's response (`rsp_valid`) and `cal_rdy` have no back-pressure. They are looked at only while the sequencer is waiting for them.

Top module: `adc_bringup_seq`

## Requirements
- R1: After synchronous reset, with no `start`, `req_valid`, `done` and `id_fail` are all 0.
- R2: After `start`, the first request is a serial reset (op 0, bytes 4, addr 0, data 0). `req_valid` then stays low for exactly WAIT_CYCLES cycles after that transfer. The next request is a read (op 2) of address 4, 1 byte.
- R3: Only `rsp_data[3:0]` is compared with EXP_ID. On a mismatch, `id_fail` rises the cycle after the response and no request follows. On a match the sequence goes on.
- R4: The first write after a good identity goes to address 1, 2 bytes. Its data is mode select in [15:13] = 2 (idle), clock source in [7:6], update rate in [3:0] = 1, and all other bits 0.
- R5: The next write goes to address 2, 2 bytes. Its data is unipolar in bit 12, gain in [10:8], reference select in [7:6], buffer in bit 4 and channel [3:0] = 0. Bits 15:13, 11 and 5 are 0.
- R6: The next write goes to address 5, 1 byte. Its data is the excitation magnitude in [1:0] and the direction in [3:2], with the upper bits 0.
- R7: Six calibration steps k = 0..5 follow. Each step writes the configuration word with channel k/2 and then the mode word with select 4 (k even) or 5 (k odd). The sequencer then issues nothing until `cal_rdy` is seen high.
- R8: `done` rises the cycle after `cal_rdy` is accepted for the sixth step, and not before. While `done` is high, `req_valid` stays 0.
- R9: A gain update that leaves the configuration word unchanged causes no request, and `done` stays high.
- R10: A gain update that changes the word drops `done`. It then writes the new word (new gain, channel still 2) to address 2 and reruns all six steps of R7, after which `done` rises again.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid` and every request field keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the bring-up sequence (taken when idle) |
| cfg_gain | input | 3 | Gain code for the configuration word |
| cfg_unipolar | input | 1 | Unipolar coding select |
| cfg_buffer | input | 1 | Input buffer enable |
| cfg_refsel | input | 2 | Reference select |
| cfg_clksrc | input | 2 | Converter clock source |
| cfg_exc_mag | input | 2 | Excitation current magnitude |
| cfg_exc_dir | input | 2 | Excitation current routing |
| gain_set | input | 1 | Gain update strobe (taken while done) |
| gain_val | input | 3 | New gain code |
| req_valid | output | 1 | Request to the register engine is valid |
| req_ready | input | 1 | Engine accepts the request |
| req_op | output | 2 | 0 serial reset, 1 write, 2 read |
| req_addr | output | 3 | Register address |
| req_bytes | output | 3 | Transfer length in bytes |
| req_data | output | 16 | Write data |
| rsp_valid | input | 1 | Read data from engine is valid |
| rsp_data | input | 8 | Read data byte |
| cal_rdy | input | 1 | Converter ready indication |
| done | output | 1 | Bring-up and calibration complete |
| id_fail | output | 1 | Identity check failed |

## Verification
The in-RTL properties check three things on every cycle. Request fields hold under back-pressure. No request leaves while `done` or `id_fail` is high. A rise of `done` or `id_fail` always follows the input that allows it.

Other behaviour shows only through the bench's scenarios: the exact order and contents of the requests, the length of the settle wait, the decision to skip on an unchanged gain word, and the rerun of the calibration script. The bench's reference model predicts each transfer and each flag for every cycle and compares them. It does this under both back-pressured and free-flowing engine timing and with two different configurations.

// File: rtl/adc_bringup_pkg.sv
package adc_bringup_pkg;
  typedef enum logic [1:0] {
    OP_SRST  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } eng_op_e;

  localparam logic [2:0] ADDR_MODE = 3'd1;
  localparam logic [2:0] ADDR_CONF = 3'd2;
  localparam logic [2:0] ADDR_ID   = 3'd4;
  localparam logic [2:0] ADDR_EXC  = 3'd5;

  localparam logic [2:0] SEL_IDLE     = 3'd2;
  localparam logic [2:0] SEL_CAL_ZERO = 3'd4;
  localparam logic [2:0] SEL_CAL_FULL = 3'd5;
  localparam logic [3:0] RATE_INIT    = 4'd1;

  typedef enum logic [3:0] {
    S_IDLE, S_SRST, S_WAIT, S_RDID, S_RSP, S_WMODE, S_WCONF, S_WEXC,
    S_CCH, S_CMODE, S_CWAIT, S_GWR, S_DONE, S_FAIL
  } seq_state_e;
endpackage

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int unsigned CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int unsigned W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [W-1:0] LOAD_VAL = W'(CYCLES - 1);

  logic [W-1:0] cnt;
  logic         running;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (load) begin
      running <= 1'b1;
      cnt     <= LOAD_VAL;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign expired = running && (cnt == '0);
endmodule

// File: rtl/adc_word_pack.sv
module adc_word_pack (
  input  logic [2:0]  mode_sel,
  input  logic [1:0]  clksrc,
  input  logic [2:0]  gain,
  input  logic        unipolar,
  input  logic        buffer,
  input  logic [1:0]  refsel,
  output logic [15:0] mode_word,
  output logic [15:0] conf_word
);
  import adc_bringup_pkg::*;

  always_comb begin
    mode_word        = '0;
    mode_word[15:13] = mode_sel;
    mode_word[7:6]   = clksrc;
    mode_word[3:0]   = RATE_INIT;

    conf_word        = '0;
    conf_word[12]    = unipolar;
    conf_word[10:8]  = gain;
    conf_word[7:6]   = refsel;
    conf_word[4]     = buffer;
    conf_word[3:0]   = 4'd0;
  end
endmodule

// File: rtl/adc_cal_script.sv
module adc_cal_script #(
  parameter int unsigned CHANNELS = 3,
  localparam int unsigned STEPS = 2 * CHANNELS,
  localparam int unsigned SW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic [SW-1:0] step,
  output logic [3:0]    chan,
  output logic [2:0]    sel,
  output logic          last
);
  import adc_bringup_pkg::*;

  localparam int unsigned TAB = 2 ** SW;

  logic [3:0] chan_tab [TAB];
  logic [2:0] sel_tab  [TAB];

  for (genvar k = 0; k < TAB; k++) begin : g_step
    if (k < STEPS) begin : g_used
      assign chan_tab[k] = 4'(k / 2);
      assign sel_tab[k]  = (k % 2 == 1) ? SEL_CAL_FULL : SEL_CAL_ZERO;
    end else begin : g_pad
      assign chan_tab[k] = 4'd0;
      assign sel_tab[k]  = SEL_IDLE;
    end
  end

  assign chan = chan_tab[step];
  assign sel  = sel_tab[step];
  assign last = (step == SW'(STEPS - 1));
endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq #(
  parameter int unsigned WAIT_CYCLES  = 50000,
  parameter logic [3:0]  EXP_ID       = 4'hB,
  parameter int unsigned CAL_CHANNELS = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [2:0]  cfg_gain,
  input  logic        cfg_unipolar,
  input  logic        cfg_buffer,
  input  logic [1:0]  cfg_refsel,
  input  logic [1:0]  cfg_clksrc,
  input  logic [1:0]  cfg_exc_mag,
  input  logic [1:0]  cfg_exc_dir,
  input  logic        gain_set,
  input  logic [2:0]  gain_val,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [1:0]  req_op,
  output logic [2:0]  req_addr,
  output logic [2:0]  req_bytes,
  output logic [15:0] req_data,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_data,
  input  logic        cal_rdy,
  output logic        done,
  output logic        id_fail
);
  import adc_bringup_pkg::*;

  localparam int unsigned STEPS = 2 * CAL_CHANNELS;
  localparam int unsigned SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  seq_state_e  state;
  logic [SW-1:0] step;
  logic [15:0] conf_q;
  logic [1:0]  clk_q;
  logic [3:0]  exc_q;

  logic        hs;
  logic        wait_over;
  logic [3:0]  cal_chan;
  logic [2:0]  cal_sel;
  logic        cal_last;
  logic [2:0]  mode_sel;
  logic [15:0] mode_word;
  logic [15:0] conf_init;
  logic [15:0] gain_word;
  logic        unused_hi;

  assign hs        = req_valid && req_ready;
  assign mode_sel  = (state == S_CMODE) ? cal_sel : SEL_IDLE;
  assign gain_word = {conf_q[15:11], gain_val, conf_q[7:0]};
  assign unused_hi = ^rsp_data[7:4];

  adc_wait_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (state == S_SRST && hs),
    .expired (wait_over)
  );

  adc_cal_script #(.CHANNELS(CAL_CHANNELS)) u_script (
    .step (step),
    .chan (cal_chan),
    .sel  (cal_sel),
    .last (cal_last)
  );

  adc_word_pack u_pack (
    .mode_sel  (mode_sel),
    .clksrc    (clk_q),
    .gain      (cfg_gain),
    .unipolar  (cfg_unipolar),
    .buffer    (cfg_buffer),
    .refsel    (cfg_refsel),
    .mode_word (mode_word),
    .conf_word (conf_init)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      step   <= '0;
      conf_q <= '0;
      clk_q  <= '0;
      exc_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state  <= S_SRST;
          clk_q  <= cfg_clksrc;
          exc_q  <= {cfg_exc_dir, cfg_exc_mag};
          conf_q <= conf_init;
        end
        S_SRST:  if (hs) state <= S_WAIT;
        S_WAIT:  if (wait_over) state <= S_RDID;
        S_RDID:  if (hs) state <= S_RSP;
        S_RSP:   if (rsp_valid)
                   state <= (rsp_data[3:0] == EXP_ID) ? S_WMODE : S_FAIL;
        S_WMODE: if (hs) state <= S_WCONF;
        S_WCONF: if (hs) state <= S_WEXC;
        S_WEXC:  if (hs) begin
          step  <= '0;
          state <= S_CCH;
        end
        S_CCH: if (hs) begin
          conf_q[3:0] <= cal_chan;
          state       <= S_CMODE;
        end
        S_CMODE: if (hs) state <= S_CWAIT;
        S_CWAIT: if (cal_rdy) begin
          if (cal_last) state <= S_DONE;
          else begin
            step  <= step + 1'b1;
            state <= S_CCH;
          end
        end
        S_DONE: if (gain_set && (gain_word != conf_q)) begin
          conf_q <= gain_word;
          state  <= S_GWR;
        end
        S_GWR: if (hs) begin
          step  <= '0;
          state <= S_CCH;
        end
        S_FAIL:  state <= S_FAIL;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid = 1'b0;
    req_op    = OP_SRST;
    req_addr  = '0;
    req_bytes = '0;
    req_data  = '0;
    unique case (state)
      S_SRST: begin
        req_valid = 1'b1;
        req_bytes = 3'd4;
      end
      S_RDID: begin
        req_valid = 1'b1;
        req_op    = OP_READ;
        req_addr  = ADDR_ID;
        req_bytes = 3'd1;
      end
      S_WMODE, S_CMODE: begin
        req_valid = 1'b1;
        req_op    = OP_WRITE;
        req_addr  = ADDR_MODE;
        req_bytes = 3'd2;
        req_data  = mode_word;
      end
      S_WCONF, S_GWR: begin
        req_valid = 1'b1;
        req_op    = OP_WRITE;
        req_addr  = ADDR_CONF;
        req_bytes = 3'd2;
        req_data  = conf_q;
      end
      S_CCH: begin
        req_valid = 1'b1;
        req_op    = OP_WRITE;
        req_addr  = ADDR_CONF;
        req_bytes = 3'd2;
        req_data  = {conf_q[15:4], cal_chan};
      end
      S_WEXC: begin
        req_valid = 1'b1;
        req_op    = OP_WRITE;
        req_addr  = ADDR_EXC;
        req_bytes = 3'd1;
        req_data  = {12'd0, exc_q};
      end
      default: ;
    endcase
  end

  assign done    = (state == S_DONE);
  assign id_fail = (state == S_FAIL);

  p_hold_req_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr)
      && $stable(req_bytes) && $stable(req_data));

  p_fail_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    id_fail |-> !req_valid);

  p_fail_after_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(id_fail) |-> $past(rsp_valid));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);

  p_done_after_rdy_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(cal_rdy));

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(done && id_fail));
endmodule

// File: tb/test_adc_bringup_seq.sv
module test_adc_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WAITC      = 20;
  localparam logic [3:0] ID = 4'hB;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [2:0]  bytes;
    logic [15:0] data;
  } req_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] cfg_gain = '0;
  logic cfg_unipolar = 1'b0, cfg_buffer = 1'b0;
  logic [1:0] cfg_refsel = '0, cfg_clksrc = '0, cfg_exc_mag = '0, cfg_exc_dir = '0;
  logic gain_set = 1'b0;
  logic [2:0] gain_val = '0;
  logic req_valid, req_ready = 1'b0;
  logic [1:0] req_op;
  logic [2:0] req_addr, req_bytes;
  logic [15:0] req_data;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_data = '0;
  logic cal_rdy = 1'b0;
  logic done, id_fail;

  adc_bringup_seq #(.WAIT_CYCLES(WAITC), .EXP_ID(ID), .CAL_CHANNELS(3)) i_adc_bringup_seq (
    .clk, .rst, .start, .cfg_gain, .cfg_unipolar, .cfg_buffer, .cfg_refsel,
    .cfg_clksrc, .cfg_exc_mag, .cfg_exc_dir, .gain_set, .gain_val,
    .req_valid, .req_ready, .req_op, .req_addr, .req_bytes, .req_data,
    .rsp_valid, .rsp_data, .cal_rdy, .done, .id_fail
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  req_t  exp_q[$];
  string tag_q[$];
  string quiet_tag = "R1";
  bit exp_done = 0, exp_fail = 0, pend_done = 0, pend_fail = 0, pend_clr = 0;
  bit bp_mode = 0, rd_checked = 1, prev_stall = 0;
  req_t prev_req;
  int rsp_cnt = 0, cal_cnt = 0, cal_runs = 0, srst_cyc = 0;
  logic [7:0] id_resp = 8'h0B;
  logic [15:0] m_conf;
  logic [1:0] m_clk;

  task automatic chk(bit ok, string tag, logic [34:0] act, logic [34:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [15:0] f_mode(logic [2:0] sel, logic [1:0] c);
    return {sel, 5'd0, c, 2'd0, 4'd1};
  endfunction

  function automatic logic [15:0] f_conf(logic [2:0] g, logic u, logic b, logic [1:0] r);
    return {2'b00, 1'b0, u, 1'b0, g, r, 1'b0, b, 4'd0};
  endfunction

  function automatic void push(logic [1:0] op, logic [2:0] a, logic [2:0] b,
                               logic [15:0] d, string tag);
    req_t e;
    e.op = op; e.addr = a; e.bytes = b; e.data = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endfunction

  // six calibration steps (R7), tagged with the requirement that triggered them
  function automatic void push_cal(string tag);
    for (int k = 0; k < 6; k++) begin
      push(2'd1, 3'd2, 3'd2, {m_conf[15:4], 4'(k / 2)}, tag);
      push(2'd1, 3'd1, 3'd2, f_mode((k % 2 == 1) ? 3'd5 : 3'd4, m_clk), tag);
    end
    m_conf[3:0] = 4'd2;
  endfunction

  // reference model, responder and comparator
  always @(negedge clk) begin
    req_t act;
    cyc++;
    if (pend_done) begin exp_done = 1; pend_done = 0; end
    if (pend_fail) begin exp_fail = 1; pend_fail = 0; end
    if (pend_clr)  begin exp_done = 0; pend_clr = 0; end
    act = {req_op, req_addr, req_bytes, req_data};
    if (!rst) begin
      chk(done == exp_done, "R8/R9/R10 done flag", 35'(done), 35'(exp_done));
      chk(id_fail == exp_fail, "R3 id_fail flag", 35'(id_fail), 35'(exp_fail));
      if (prev_stall)
        chk(req_valid && act == prev_req, "R11 hold under back-pressure",
            {req_valid, act[33:0]}, {1'b1, prev_req[33:0]});
    end
    req_ready = bp_mode ? (cyc % 3 == 2) : 1'b1;
    if (!rst && req_valid) begin
      if (req_op == 2'd2 && !rd_checked) begin
        rd_checked = 1;
        chk(cyc - srst_cyc == WAITC + 1, "R2 settle wait",
            35'(cyc - srst_cyc), 35'(WAITC + 1));
      end
      if (exp_q.size() == 0) begin
        chk(0, {quiet_tag, " unexpected request"}, act, '0);
      end else if (req_ready) begin
        req_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(act == e, t, act, e);
        if (req_op == 2'd0) begin srst_cyc = cyc; rd_checked = 0; end
        if (req_op == 2'd2) rsp_cnt = 2;
        if (req_op == 2'd1 && req_addr == 3'd1 && req_data[15:13] >= 3'd4) cal_cnt = 3;
      end
    end
    prev_stall = !rst && req_valid && !req_ready;
    prev_req = act;
    rsp_valid = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = id_resp;
        if (id_resp[3:0] != ID) pend_fail = 1;
        else begin
          push(2'd1, 3'd1, 3'd2, f_mode(3'd2, m_clk), "R4");
          push(2'd1, 3'd2, 3'd2, m_conf, "R5");
          push(2'd1, 3'd5, 3'd1, {12'd0, cfg_exc_dir, cfg_exc_mag}, "R6");
          push_cal("R7");
        end
      end
    end
    cal_rdy = 1'b0;
    if (cal_cnt > 0) begin
      cal_cnt--;
      if (cal_cnt == 0) begin
        cal_rdy = 1'b1;
        cal_runs++;
        if (cal_runs == 6) pend_done = 1;
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    exp_q.delete(); tag_q.delete();
    exp_done = 0; exp_fail = 0; pend_done = 0; pend_fail = 0; pend_clr = 0;
    rsp_cnt = 0; cal_cnt = 0; cal_runs = 0; rd_checked = 1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic run(logic [2:0] g, logic u, logic b, logic [1:0] r, logic [1:0] c,
                     logic [1:0] mg, logic [1:0] dr, logic [7:0] idv);
    cfg_gain = g; cfg_unipolar = u; cfg_buffer = b; cfg_refsel = r;
    cfg_clksrc = c; cfg_exc_mag = mg; cfg_exc_dir = dr; id_resp = idv;
    m_conf = f_conf(g, u, b, r); m_clk = c; cal_runs = 0;
    quiet_tag = "R2";
    push(2'd0, 3'd0, 3'd4, 16'd0, "R2");
    push(2'd2, 3'd4, 3'd1, 16'd0, "R2");
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 3000 && !exp_done && !exp_fail; i++) tick();
    chk(exp_done || exp_fail, "R8 sequence completes", 35'(done), 35'd1);
  endtask

  task automatic gain_update(logic [2:0] g);
    logic [15:0] nw;
    nw = {m_conf[15:11], g, m_conf[7:0]};
    gain_val = g; gain_set = 1'b1;
    if (nw != m_conf) begin
      m_conf = nw;
      pend_clr = 1;
      cal_runs = 0;
      quiet_tag = "R10";
      push(2'd1, 3'd2, 3'd2, m_conf, "R10");
      push_cal("R10");
    end else quiet_tag = "R9";
    tick(); gain_set = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    quiet_tag = "R1";
    repeat (6) tick();

    // bad identity: upper nibble matches nothing, lower nibble wrong (R3)
    run(3'd1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd1, 2'd0, 8'h3A);
    wait_flag();
    quiet_tag = "R3";
    repeat (30) tick();

    // good identity with junk in upper nibble, back-pressured engine
    do_reset();
    bp_mode = 1;
    run(3'd3, 1'b1, 1'b1, 2'd2, 2'd2, 2'd2, 2'd1, 8'h5B);
    wait_flag();
    quiet_tag = "R8";
    repeat (10) tick();
    gain_update(3'd3);
    repeat (30) tick();
    gain_update(3'd6);
    wait_flag();
    quiet_tag = "R8";
    repeat (10) tick();

    // free-flowing engine, other configuration
    do_reset();
    bp_mode = 0;
    run(3'd0, 1'b0, 1'b0, 2'd1, 2'd1, 2'd3, 2'd3, 8'h0B);
    wait_flag();
    repeat (5) tick();
    gain_update(3'd0);
    repeat (20) tick();
    gain_update(3'd7);
    wait_flag();
    repeat (10) tick();
    chk(exp_q.size() == 0, "R10 all expected requests issued", 35'(exp_q.size()), 35'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired (R8) actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule